// File: doc/BRIEF.md
# Stereo Digital Volume with Soft Gain Ramp

This block sits in a stereo playback path ahead of the interpolation stage and scales each PCM sample pair by a per-channel gain. Sample pairs arrive on a valid/ready stream of signed 24-bit left and right words. They leave on a second valid/ready stream, one output pair for each accepted input pair, scaled, rounded and clipped to 24 bits. Gain is selected by an 8-bit code per channel. Each step of the code is 0.375 dB. Code 192 is unity gain and code 0 is silence. The code is turned into a linear multiplier from a 16-entry mantissa table and an octave shift. Sixteen steps of the code make one octave, which is about 6 dB.

Volume codes are written into staging registers and only take effect when a commit strobe is pulsed. Three mute controls decide the code that each channel heads toward: a mute for each channel and one global mute. The global mute is set out of reset. With ramping off, the gain jumps to the target code. With ramping on, the gain moves one code toward the target on every second accepted sample. This applies to volume changes and also to muting and unmuting, so the audible level never steps abruptly. The gain only ever changes at the moment a sample is accepted.

Stream rules: an input pair is accepted on a clock edge where `s_valid` and `s_ready` are both high. `s_ready` is high whenever the output register is empty or is being drained in that cycle (`m_ready` high). The scaled pair appears on `m_data_l`/`m_data_r` with `m_valid` high one cycle after acceptance. It stays unchanged for as long as `m_ready` is low.

Top module: `svol_top`

## Requirements
- R1: For a gain code c from 1 to 255, let q = c[7:4] and m = c[3:0], and let M = round(2^(m/16) * 16384). The output is floor((x*M + 2^(sh-1)) / 2^sh) with sh = 26 - q, clipped as in R8. This approximates 0.375*(c-192) dB, and c = 192 passes x through unchanged.
- R2: A sample processed with gain code 0 produces an output of exactly 0.
- R3: A write on `vol_wr` loads `vol_code` into the staging register selected by `vol_sel` (0 = left, 1 = right) and leaves the active code unchanged. A pulse on `vol_commit` copies both staging registers into the active codes. Staging and active codes reset to 192.
- R4: After reset, global mute is 1, the channel mutes and ramp enable are 0, the gain code of both channels is 0, `m_valid` is 0 and `s_ready` is 1. Samples accepted before the first control write are output as 0.
- R5: A channel's target code is 0 when its own mute or the global mute is set, and its active code otherwise. Mutes are written on `ctl_wr`.
- R6: With ramping enabled, a phase bit toggles on each accepted sample and is cleared while ramping is off. An accepted sample whose phase bit is 1 moves the gain code one step toward the target. That sample uses the new code. Other samples keep the current code.
- R7: With ramping disabled, an accepted sample takes the current target code as its gain code and uses it.
- R8: Results above 8388607 give 8388607, and results below -8388608 give -8388608. A positive input never yields a negative output.
- R9: Left and right gain codes, mutes and ramps evolve independently, and each channel's output depends only on its own input.
- R10: The gain code changes only on a sample acceptance. An output pair held while `m_ready` is low stays stable with `m_valid` high, and `s_ready` is low during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input sample pair valid |
| s_ready | output | 1 | Block can accept a pair |
| s_data_l | input | 24 | Left input sample, signed |
| s_data_r | input | 24 | Right input sample, signed |
| m_valid | output | 1 | Output pair valid |
| m_ready | input | 1 | Downstream accepts the output pair |
| m_data_l | output | 24 | Scaled left sample, signed |
| m_data_r | output | 24 | Scaled right sample, signed |
| vol_wr | input | 1 | Write strobe for a staging code |
| vol_sel | input | 1 | Staging register select, 0 left, 1 right |
| vol_code | input | 8 | Code to stage |
| vol_commit | input | 1 | Copy both staged codes to active |
| ctl_wr | input | 1 | Write strobe for mute and ramp controls |
| ctl_mute_l | input | 1 | Left channel mute |
| ctl_mute_r | input | 1 | Right channel mute |
| ctl_mute_all | input | 1 | Global mute |
| ctl_ramp_en | input | 1 | Soft ramp enable |

## Verification
The hardest state to reach from the ports is a ramp in progress that gets retargeted. This happens when a new commit or a mute write arrives halfway through a slope, when the step phase is odd, or while the output is stalled, so that a step must not be lost or doubled. The stimulus starts directed ramps down and up, then lets a long random sequence interleave commits, mute flips and ramp toggles with sample pushes and random stalls. Every output is compared with a bench model that tracks the phase bit and per-channel codes. Directed full-scale samples at codes above 192 and at code 0 cover clipping and silence.

// File: rtl/svol_pkg.sv
package svol_pkg;
  localparam int CODE_W     = 8;
  localparam int UNITY_CODE = 192;
  localparam int MANT_W     = 16;
  localparam int MANT_FRAC  = 14;
  localparam int OCT_UNITY  = UNITY_CODE / 16;
  localparam int SHIFT_BASE = MANT_FRAC + OCT_UNITY;

  // 2^(m/16) in Q1.14, rounded to nearest
  function automatic logic [MANT_W-1:0] mant_of(input logic [3:0] m);
    case (m)
      4'd0:  return 16'd16384;
      4'd1:  return 16'd17109;
      4'd2:  return 16'd17867;
      4'd3:  return 16'd18658;
      4'd4:  return 16'd19484;
      4'd5:  return 16'd20347;
      4'd6:  return 16'd21247;
      4'd7:  return 16'd22188;
      4'd8:  return 16'd23170;
      4'd9:  return 16'd24196;
      4'd10: return 16'd25268;
      4'd11: return 16'd26386;
      4'd12: return 16'd27554;
      4'd13: return 16'd28774;
      4'd14: return 16'd30048;
      default: return 16'd31379;
    endcase
  endfunction

  typedef struct packed {
    logic mute_l;
    logic mute_r;
    logic mute_all;
    logic ramp_en;
  } svol_ctl_t;
endpackage

// File: rtl/svol_regs.sv
module svol_regs
  import svol_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        vol_wr,
  input  logic [$clog2(NCH)-1:0]      vol_sel,
  input  logic [CODE_W-1:0]           vol_code,
  input  logic                        vol_commit,
  input  logic                        ctl_wr,
  input  svol_ctl_t                   ctl_in,
  output logic [NCH-1:0][CODE_W-1:0]  tgt_code,
  output logic                        ramp_en
);
  svol_ctl_t ctl_q;
  logic [NCH-1:0] ch_mute;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '{mute_l: 1'b0, mute_r: 1'b0, mute_all: 1'b1, ramp_en: 1'b0};
    end else if (ctl_wr) begin
      ctl_q <= ctl_in;
    end
  end

  assign ch_mute[0] = ctl_q.mute_l;
  if (NCH > 1) begin : g_rmute
    assign ch_mute[NCH-1:1] = {(NCH-1){ctl_q.mute_r}};
  end
  assign ramp_en = ctl_q.ramp_en;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [CODE_W-1:0] stage_q, act_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage_q <= CODE_W'(UNITY_CODE);
        act_q   <= CODE_W'(UNITY_CODE);
      end else begin
        if (vol_wr && (vol_sel == ch)) stage_q <= vol_code;
        if (vol_commit) act_q <= stage_q;
      end
    end
    assign tgt_code[ch] = (ctl_q.mute_all || ch_mute[ch]) ? '0 : act_q;
  end
endmodule

// File: rtl/svol_track.sv
module svol_track
  import svol_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              ramp_en,
  input  logic              step_now,
  input  logic [CODE_W-1:0] tgt,
  output logic [CODE_W-1:0] cur,
  output logic [CODE_W-1:0] gcode
);
  logic [CODE_W-1:0] stepped;

  always_comb begin
    if (cur < tgt)      stepped = cur + 1'b1;
    else if (cur > tgt) stepped = cur - 1'b1;
    else                stepped = cur;
  end

  always_comb begin
    if (!ramp_en)      gcode = tgt;
    else if (step_now) gcode = stepped;
    else               gcode = cur;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    cur <= '0;
    else if (fire) cur <= gcode;
  end
endmodule

// File: rtl/svol_scale.sv
module svol_scale
  import svol_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic signed [DATA_W-1:0] din,
  input  logic [CODE_W-1:0]        code,
  output logic signed [DATA_W-1:0] dout
);
  localparam int PROD_W = DATA_W + MANT_W + 1;
  localparam int SH_W   = 6;
  localparam logic signed [PROD_W-1:0] SAT_HI = PROD_W'((64'sd1 <<< (DATA_W-1)) - 1);
  localparam logic signed [PROD_W-1:0] SAT_LO = -PROD_W'(64'sd1 <<< (DATA_W-1));

  logic [MANT_W-1:0]        mant;
  logic [SH_W-1:0]          sh;
  logic signed [PROD_W-1:0] prod, half, rnd, scaled;

  always_comb begin
    mant   = mant_of(code[3:0]);
    sh     = SH_W'(SHIFT_BASE) - SH_W'(code[CODE_W-1:4]);
    prod   = PROD_W'(din) * PROD_W'($signed({1'b0, mant}));
    half   = PROD_W'(1) <<< (sh - SH_W'(1));
    rnd    = prod + half;
    scaled = rnd >>> sh;
    if (code == '0)          dout = '0;
    else if (scaled > SAT_HI) dout = SAT_HI[DATA_W-1:0];
    else if (scaled < SAT_LO) dout = SAT_LO[DATA_W-1:0];
    else                      dout = scaled[DATA_W-1:0];
  end
endmodule

// File: rtl/svol_top.sv
module svol_top
  import svol_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data_l,
  input  logic [DATA_W-1:0] s_data_r,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data_l,
  output logic [DATA_W-1:0] m_data_r,
  input  logic              vol_wr,
  input  logic              vol_sel,
  input  logic [7:0]        vol_code,
  input  logic              vol_commit,
  input  logic              ctl_wr,
  input  logic              ctl_mute_l,
  input  logic              ctl_mute_r,
  input  logic              ctl_mute_all,
  input  logic              ctl_ramp_en
);
  localparam int NCH = 2;

  logic [NCH-1:0][CODE_W-1:0] tgt_code, cur_code, g_code;
  logic [NCH-1:0][DATA_W-1:0] din, dout;
  logic                       ramp_en, phase_q, fire;
  svol_ctl_t                  ctl_in;

  assign ctl_in  = '{mute_l: ctl_mute_l, mute_r: ctl_mute_r,
                     mute_all: ctl_mute_all, ramp_en: ctl_ramp_en};
  assign s_ready = !m_valid || m_ready;
  assign fire    = s_valid && s_ready;
  assign din[0]  = s_data_l;
  assign din[1]  = s_data_r;

  svol_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .vol_wr(vol_wr), .vol_sel(vol_sel), .vol_code(vol_code),
    .vol_commit(vol_commit), .ctl_wr(ctl_wr), .ctl_in(ctl_in),
    .tgt_code(tgt_code), .ramp_en(ramp_en)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)    phase_q <= 1'b0;
    else if (fire) phase_q <= ramp_en ? !phase_q : 1'b0;
    else if (!ramp_en) phase_q <= 1'b0;
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    svol_track u_track (
      .clk(clk), .rst_n(rst_n), .fire(fire), .ramp_en(ramp_en),
      .step_now(phase_q), .tgt(tgt_code[ch]),
      .cur(cur_code[ch]), .gcode(g_code[ch])
    );
    svol_scale #(.DATA_W(DATA_W)) u_scale (
      .din(din[ch]), .code(g_code[ch]), .dout(dout[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid  <= 1'b0;
      m_data_l <= '0;
      m_data_r <= '0;
    end else if (fire) begin
      m_valid  <= 1'b1;
      m_data_l <= dout[0];
      m_data_r <= dout[1];
    end else if (m_ready) begin
      m_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/svol_chk.sv
module svol_chk #(
  parameter int DATA_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_valid,
  input logic              s_ready,
  input logic [DATA_W-1:0] s_data_l,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data_l,
  input logic [DATA_W-1:0] m_data_r,
  input logic [7:0]        g_l,
  input logic [7:0]        g_r,
  input logic [7:0]        cur_l,
  input logic [7:0]        cur_r,
  input logic              ramp_en
);
  logic s_fire;
  assign s_fire = s_valid && s_ready;

  AST_MUTE_ZERO_L: assert property (@(posedge clk) disable iff (!rst_n)
    s_fire && (g_l == 8'd0) |=> (m_data_l == '0)); // R2
  AST_MUTE_ZERO_R: assert property (@(posedge clk) disable iff (!rst_n)
    s_fire && (g_r == 8'd0) |=> (m_data_r == '0)); // R2
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    s_fire && (g_l != 8'd0) && !s_data_l[DATA_W-1] |=> !m_data_l[DATA_W-1]); // R8
  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    s_fire && ramp_en |=> (cur_l == $past(cur_l)) || (cur_l == $past(cur_l) + 8'd1)
                          || (cur_l == $past(cur_l) - 8'd1)); // R6
  AST_GAIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !s_fire |=> $stable(cur_l) && $stable(cur_r)); // R10
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data_l) && $stable(m_data_r)); // R10
endmodule

bind svol_top svol_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .s_data_l(s_data_l), .m_valid(m_valid), .m_ready(m_ready),
  .m_data_l(m_data_l), .m_data_r(m_data_r),
  .g_l(g_code[0]), .g_r(g_code[1]), .cur_l(cur_code[0]), .cur_r(cur_code[1]),
  .ramp_en(ramp_en)
);

// File: tb/svol_top_bench.sv
module svol_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, m_ready = 1'b1;
  logic s_ready, m_valid;
  logic [23:0] s_data_l = '0, s_data_r = '0, m_data_l, m_data_r;
  logic vol_wr = 1'b0, vol_sel = 1'b0, vol_commit = 1'b0;
  logic [7:0] vol_code = '0;
  logic ctl_wr = 1'b0, ctl_mute_l = 1'b0, ctl_mute_r = 1'b0, ctl_mute_all = 1'b0, ctl_ramp_en = 1'b0;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // model state
  int stg[2], act[2], cur[2];
  bit mu[2], mall, ramp, phase;

  always #2.5 clk = ~clk;

  svol_top u_svol_top (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data_l(s_data_l), .s_data_r(s_data_r), .m_valid(m_valid), .m_ready(m_ready),
    .m_data_l(m_data_l), .m_data_r(m_data_r), .vol_wr(vol_wr), .vol_sel(vol_sel),
    .vol_code(vol_code), .vol_commit(vol_commit), .ctl_wr(ctl_wr),
    .ctl_mute_l(ctl_mute_l), .ctl_mute_r(ctl_mute_r), .ctl_mute_all(ctl_mute_all),
    .ctl_ramp_en(ctl_ramp_en)
  );

  task automatic chk(input bit ok, input string tag, input longint actv, input longint expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actv, expv);
    end
  endtask

  function automatic longint exp_out(input logic signed [23:0] x, input int c);
    longint p, r, mv;
    int q, m, sh;
    if (c == 0) return 0;
    q  = c / 16;
    m  = c % 16;
    mv = longint'($rtoi(2.0 ** (real'(m) / 16.0) * 16384.0 + 0.5));
    p  = longint'(x) * mv;
    sh = 26 - q;
    r  = (p + (longint'(1) <<< (sh - 1))) >>> sh;
    if (r > 8388607) r = 8388607;
    if (r < -8388608) r = -8388608;
    return r;
  endfunction

  task automatic set_ctl(input bit ml, input bit mr, input bit ma, input bit rp);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_mute_l = ml; ctl_mute_r = mr; ctl_mute_all = ma; ctl_ramp_en = rp;
    @(negedge clk);
    ctl_wr = 1'b0;
    mu[0] = ml; mu[1] = mr; mall = ma; ramp = rp;
    if (!rp) phase = 1'b0;
  endtask

  task automatic stage(input int sel, input int code);
    @(negedge clk);
    vol_wr = 1'b1; vol_sel = sel[0]; vol_code = code[7:0];
    @(negedge clk);
    vol_wr = 1'b0;
    stg[sel] = code;
  endtask

  task automatic commit();
    @(negedge clk);
    vol_commit = 1'b1;
    @(negedge clk);
    vol_commit = 1'b0;
    act[0] = stg[0]; act[1] = stg[1];
  endtask

  task automatic push(input logic [23:0] l, input logic [23:0] r, input bit stall, input string tag);
    longint el, er;
    @(negedge clk);
    m_ready = 1'b1; s_valid = 1'b1; s_data_l = l; s_data_r = r;
    @(posedge clk);
    for (int ch = 0; ch < 2; ch++) begin
      int tgt, g;
      tgt = (mall || mu[ch]) ? 0 : act[ch];
      if (!ramp) g = tgt;
      else if (phase) g = (cur[ch] < tgt) ? cur[ch] + 1 : (cur[ch] > tgt) ? cur[ch] - 1 : cur[ch];
      else g = cur[ch];
      cur[ch] = g;
    end
    phase = ramp ? !phase : 1'b0;
    el = exp_out(l, cur[0]);
    er = exp_out(r, cur[1]);
    @(negedge clk);
    s_valid = 1'b0;
    chk(m_valid === 1'b1, "R10", longint'(m_valid), 1);
    chk($signed(m_data_l) == el, tag, longint'($signed(m_data_l)), el);
    chk($signed(m_data_r) == er, tag, longint'($signed(m_data_r)), er);
    if (stall) begin
      m_ready = 1'b0;
      @(negedge clk);
      chk(s_ready === 1'b0, "R10", longint'(s_ready), 0);
      chk($signed(m_data_l) == el && m_valid, "R10", longint'($signed(m_data_l)), el);
      m_ready = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd4242);
    stg = '{192, 192}; act = '{192, 192}; cur = '{0, 0};
    mu = '{0, 0}; mall = 1'b1; ramp = 1'b0; phase = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4: reset state
    chk(m_valid === 1'b0, "R4", longint'(m_valid), 0);
    chk(s_ready === 1'b1, "R4", longint'(s_ready), 1);
    push(24'h123456, 24'hABCDEF, 1'b0, "R4");
    @(negedge clk);
    chk(m_valid === 1'b0, "R10", longint'(m_valid), 0);

    // R7 / R1: unmute without ramp, unity pass-through
    set_ctl(0, 0, 0, 0);
    push(24'h234567, 24'hF00001, 1'b0, "R7");
    chk(cur[0] == 192, "R1", cur[0], 192);

    // R3: staged code not active until commit
    stage(0, 100);
    stage(1, 220);
    push(24'h100000, 24'h100000, 1'b0, "R3");
    chk($signed(m_data_l) == 24'sh100000, "R3", longint'($signed(m_data_l)), 24'h100000);
    commit();
    push(24'h100000, 24'h100000, 1'b1, "R9");

    // R8: saturation with top code and full-scale input
    stage(0, 255); stage(1, 255); commit();
    push(24'h7FFFFF, 24'h800000, 1'b0, "R8");
    chk($signed(m_data_l) == 8388607, "R8", longint'($signed(m_data_l)), 8388607);
    chk($signed(m_data_r) == -8388608, "R8", longint'($signed(m_data_r)), -8388608);

    // R2: code 0 silences
    stage(0, 0); stage(1, 1); commit();
    push(24'h7FFFFF, 24'h7FFFFF, 1'b0, "R2");
    chk(m_data_l == 24'd0, "R2", longint'(m_data_l), 0);

    // R5: per-channel and global mute
    stage(0, 192); stage(1, 192); commit();
    set_ctl(1, 0, 0, 0);
    push(24'h001234, 24'h001234, 1'b0, "R5");
    chk(m_data_l == 24'd0 && m_data_r == 24'h001234, "R5", longint'(m_data_l), 0);
    set_ctl(0, 0, 1, 0);
    push(24'h001234, 24'h001234, 1'b0, "R5");
    set_ctl(0, 0, 0, 0);
    push(24'h001234, 24'h001234, 1'b0, "R5");

    // R6: ramp down then retarget mid-ramp, then mute ramp
    set_ctl(0, 0, 0, 1);
    stage(0, 180); stage(1, 200); commit();
    for (int i = 0; i < 30; i++) push(24'($urandom), 24'($urandom), i[2], "R6");
    chk(cur[0] == 180 && cur[1] == 200, "R6", cur[0], 180);
    stage(0, 190); commit();
    for (int i = 0; i < 7; i++) push(24'h300000, 24'h300000, 1'b0, "R6");
    set_ctl(0, 1, 0, 1);
    for (int i = 0; i < 20; i++) push(24'h300000, 24'h300000, 1'b0, "R6");

    // random mix
    for (int it = 0; it < 500; it++) begin
      int op;
      op = int'($urandom % 16);
      if (op == 0) stage(int'($urandom % 2), 150 + int'($urandom % 106));
      else if (op == 1) stage(int'($urandom % 2), int'($urandom % 256));
      else if (op == 2) commit();
      else if (op == 3) set_ctl($urandom % 4 == 0, $urandom % 4 == 0, $urandom % 8 == 0, $urandom % 2 == 1);
      else push(24'($urandom), 24'($urandom), ($urandom % 3) == 0, "R1");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule